// File: doc/BRIEF.md
# Fractional Resampler with Farrow Interpolator

This block moves a complex (I/Q) baseband stream from an input sample grid onto the output clock grid when the two rates have no integer relationship. A 32-bit phase accumulator is clocked at the output rate. On each clock it adds a rate step: the programmed frequency control word plus a signed run-time correction, for example from an external timing loop. A carry out of the accumulator means one new input sample is due. The block then raises its take strobe and captures the sample presented at its input into a four-deep delay line for each lane.

The carry also drives a counter that produces a cascade of divided strobes at one half, one quarter and one eighth of the take rate. The upstream interpolating filters use these strobes, and the eighth-rate strobe asks the symbol source for its next symbol. The top bits of the accumulator are the fractional position of the output instant between two input samples. A cubic Lagrange interpolator in Farrow form evaluates the polynomial through the four held samples at that position and writes one registered output sample per clock. A new input symbol rate needs only a different control word.

Top module: `farrow_resampler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, the strobe counter, every delay-line entry and the sample fill count are cleared. `out_i`, `out_q` and `out_valid` read 0 after that edge.
- R2: The rate step is `(fcw + sign-extended freq_corr) mod 2^32`. On every clock the accumulator adds this step modulo 2^32. `in_take` is high in a cycle exactly when that addition carries out of bit 31.
- R3: `freq_corr` is a signed two's-complement value, and a negative value slows the take rate. Starting from reset, the number of cycles with `in_take` high among the first N cycles equals floor(N*step/2^32).
- R4: `stb_div[k]` (k = 0..2) is high only together with `in_take`, on take number j (0-based, counted since reset) when j mod 2^(k+1) = 0. `stb_div[2]` is the next-symbol request.
- R5: At an edge where `in_take` is high, `in_i`/`in_q` become the newest delay-line entry and the older entries each move one place back. At other edges the delay line holds its contents.
- R6: Let the entries before an edge be x0 (newest), x1, x2 and x3 (oldest), and let mu be accumulator bits [31:20] divided by 4096. The output after that edge is the cubic through (-2,x3), (-1,x2), (0,x1), (1,x0), evaluated at mu and rounded to the nearest integer, within 1 LSB.
- R7: When mu is 0, the output after the edge equals x1 exactly.
- R8: An interpolated value outside the 12-bit signed range is clamped to 2047 or -2048.
- R9: `out_valid` goes high at the edge after the edge that captures the fourth sample since reset, and it stays high until the next reset.
- R10: The I and Q lanes use the same timing and the same formula, each on its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fcw | input | 32 | Frequency control word (input/output rate ratio times 2^32) |
| freq_corr | input | 16 | Signed frequency correction added to `fcw` |
| in_i | input | 12 | In-phase input sample, signed |
| in_q | input | 12 | Quadrature input sample, signed |
| in_take | output | 1 | Input sample is captured at this edge |
| stb_div | output | 3 | Divided strobes at 1/2, 1/4 and 1/8 of the take rate |
| out_i | output | 12 | Interpolated in-phase output, signed |
| out_q | output | 12 | Interpolated quadrature output, signed |
| out_valid | output | 1 | Output holds a sample built from four real inputs |

## Verification
`in_take` and `stb_div` are combinational in the step inputs and the current accumulator, so the bench reads them one nanosecond after driving the inputs, in the same cycle. The interpolated samples and `out_valid` are registered once. The bench predicts their values from the model state just before an edge and compares them at the falling edge that follows. A reference model updated at each edge tracks the accumulator, the delay line and the fill count. The sweeps cover step values that give every fractional position, fixed quarter-step positions, full-scale patterns that saturate, and signed corrections.

// File: rtl/resamp_pkg.sv
`timescale 1ns/1ps
// Shared constants for the fractional resampler.
// Assumes exactly two lanes (I and Q) and a cubic interpolator.
package resamp_pkg;
    localparam int LANES = 2;
    localparam int TAPS  = 4;

    // Rounded reciprocal of six, scaled by 2^k.
    function automatic int recip6(input int k);
        return ((1 << k) + 3) / 6;
    endfunction
endpackage

// File: rtl/resamp_nco.sv
`timescale 1ns/1ps
// Phase accumulator running on the output clock.
// Adds fcw plus a sign-extended correction on each clock. The carry out
// is the input-sample take strobe. The top MUW bits are the fractional
// interval. A wrap counter gives strobes at 1/2^(k+1) of the take rate.
// Assumes CORR_W <= ACC_W and MUW <= ACC_W.
module resamp_nco #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16,
    parameter int MUW    = 12,
    parameter int NDIV   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  fcw,
    input  logic [CORR_W-1:0] corr,
    output logic              take,
    output logic [NDIV-1:0]   stb_div,
    output logic [MUW-1:0]    mu
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;
    logic [NDIV-1:0]  wcnt;

    // Rate step and carry detection.
    always_comb begin
        step = fcw + {{(ACC_W-CORR_W){corr[CORR_W-1]}}, corr};
        sum  = {1'b0, acc} + {1'b0, step};
    end

    assign take = sum[ACC_W];
    assign mu   = acc[ACC_W-1 -: MUW];

    // Accumulator and wrap counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            wcnt <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
            if (take) wcnt <= wcnt + 1'b1;
        end
    end

    // Divided strobe cascade, one per division stage.
    for (genvar k = 0; k < NDIV; k++) begin : g_div
        assign stb_div[k] = take && (wcnt[k:0] == '0);
    end

    // R2: a carry leaves a smaller accumulator, no carry leaves it no smaller.
    p_take_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (acc < $past(acc)));
    p_hold_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (acc >= $past(acc)));
    // R4: the slowest strobe never fires on two consecutive clocks.
    p_sym_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_div[NDIV-1] |=> !stb_div[NDIV-1]);
endmodule

// File: rtl/resamp_dline.sv
`timescale 1ns/1ps
// Delay line for one lane. Shifts in din when shift is high.
// The taps output is flattened with entry 0 (newest) in the low bits.
module resamp_dline #(
    parameter int SW   = 12,
    parameter int TAPS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic [SW-1:0]      din,
    output logic [TAPS*SW-1:0] taps
);
    logic [SW-1:0] tap_q [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        // One stage of the shift register.
        always_ff @(posedge clk) begin
            if (!rst_n)     tap_q[k] <= '0;
            else if (shift) tap_q[k] <= (k == 0) ? din : tap_q[(k == 0) ? 0 : k-1];
        end
        assign taps[k*SW +: SW] = tap_q[k];
    end

    // R5: entries move back one place on a shift and hold otherwise.
    p_shift_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (taps[2*SW-1:SW] == $past(taps[SW-1:0])));
    p_hold_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(taps));
endmodule

// File: rtl/resamp_farrow.sv
`timescale 1ns/1ps
// Cubic Lagrange interpolator in Farrow form for one lane, one register.
// The nodes are x3@-2, x2@-1, x1@0, x0@1, evaluated at mu/2^MUW.
// The coefficients are scaled by 6 so that they are integers (shift-add).
// Horner evaluation keeps full precision. One constant multiply by
// round(2^RK/6) then removes the scale, followed by rounding and
// saturation to SW bits.
module resamp_farrow #(
    parameter int SW  = 12,
    parameter int MUW = 12,
    parameter int RK  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] x0,
    input  logic signed [SW-1:0] x1,
    input  logic signed [SW-1:0] x2,
    input  logic signed [SW-1:0] x3,
    input  logic [MUW-1:0]       mu,
    output logic signed [SW-1:0] y
);
    import resamp_pkg::*;

    localparam int CW  = SW + 6;
    localparam int S1W = CW + MUW + 2;
    localparam int S2W = S1W + MUW + 1;
    localparam int S3W = S2W + MUW + 1;
    localparam int PW  = S3W + RK + 1;
    localparam int SH  = RK + 3*MUW;
    localparam logic signed [PW-1:0] RC = PW'(recip6(RK));

    logic signed [CW-1:0]  e0, e1, e2, e3, d03, d21, s02, d02;
    logic signed [CW-1:0]  c3, c2, c1, c0;
    logic signed [S1W-1:0] c3x, c2x, m1, s1;
    logic signed [S2W-1:0] s1x, c1x, m2, s2;
    logic signed [S3W-1:0] s2x, c0x, m3, s3;
    logic signed [PW-1:0]  s3x, prod, half, yw, maxv, minv;
    logic signed [SW-1:0]  ysat;

    assign half = {{(PW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
    assign maxv = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    assign minv = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

    // Coefficient branches (times 6), built from shift-add only.
    always_comb begin
        e0  = {{(CW-SW){x0[SW-1]}}, x0};
        e1  = {{(CW-SW){x1[SW-1]}}, x1};
        e2  = {{(CW-SW){x2[SW-1]}}, x2};
        e3  = {{(CW-SW){x3[SW-1]}}, x3};
        d03 = e0 - e3;
        d21 = e2 - e1;
        c3  = d03 + (d21 <<< 1) + d21;
        s02 = e0 + e2 - (e1 <<< 1);
        c2  = (s02 <<< 1) + s02;
        d02 = e0 - e2;
        c1  = (d02 <<< 1) + d02 - c3;
        c0  = ((e1 <<< 1) + e1) <<< 1;
    end

    // Horner stages at full precision.
    always_comb begin
        c3x = {{(S1W-CW){c3[CW-1]}}, c3};
        c2x = {{(S1W-CW){c2[CW-1]}}, c2};
        m1  = {{(S1W-MUW){1'b0}}, mu};
        s1  = c3x * m1 + (c2x <<< MUW);
        s1x = {{(S2W-S1W){s1[S1W-1]}}, s1};
        c1x = {{(S2W-CW){c1[CW-1]}}, c1};
        m2  = {{(S2W-MUW){1'b0}}, mu};
        s2  = s1x * m2 + (c1x <<< (2*MUW));
        s2x = {{(S3W-S2W){s2[S2W-1]}}, s2};
        c0x = {{(S3W-CW){c0[CW-1]}}, c0};
        m3  = {{(S3W-MUW){1'b0}}, mu};
        s3  = s2x * m3 + (c0x <<< (3*MUW));
    end

    // Remove the scale by 6 and 2^(3*MUW), round, then saturate.
    always_comb begin
        s3x  = {{(PW-S3W){s3[S3W-1]}}, s3};
        prod = s3x * RC;
        yw   = (prod + half) >>> SH;
        if (yw > maxv)      ysat = {1'b0, {(SW-1){1'b1}}};
        else if (yw < minv) ysat = {1'b1, {(SW-1){1'b0}}};
        else                ysat = yw[SW-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= ysat;
    end

    // R7: a zero fraction passes the second-newest sample through exactly.
    p_mu_zero_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mu == '0) |=> (y == $past(x1)));
endmodule

// File: rtl/farrow_resampler.sv
`timescale 1ns/1ps
// Fractional I/Q resampler, top level.
// One NCO provides the take strobe, the divided strobes and the fraction.
// Each lane has its own delay line and Farrow interpolator.
// Assumes the upstream source holds in_i/in_q valid whenever in_take is high.
module farrow_resampler #(
    parameter int SW     = 12,
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16,
    parameter int MUW    = 12,
    parameter int NDIV   = 3,
    parameter int RK     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  fcw,
    input  logic [CORR_W-1:0] freq_corr,
    input  logic [SW-1:0]     in_i,
    input  logic [SW-1:0]     in_q,
    output logic              in_take,
    output logic [NDIV-1:0]   stb_div,
    output logic [SW-1:0]     out_i,
    output logic [SW-1:0]     out_q,
    output logic              out_valid
);
    import resamp_pkg::*;

    localparam int FILL_W = $clog2(TAPS + 1);

    logic [MUW-1:0]    mu;
    logic [FILL_W-1:0] fill;
    logic [SW-1:0]     lane_in  [LANES];
    logic [SW-1:0]     lane_out [LANES];

    resamp_nco #(
        .ACC_W (ACC_W),
        .CORR_W(CORR_W),
        .MUW   (MUW),
        .NDIV  (NDIV)
    ) nco_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fcw    (fcw),
        .corr   (freq_corr),
        .take   (in_take),
        .stb_div(stb_div),
        .mu     (mu)
    );

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;
    assign out_i      = lane_out[0];
    assign out_q      = lane_out[1];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TAPS*SW-1:0] taps;

        resamp_dline #(.SW(SW), .TAPS(TAPS)) dline_i (
            .clk  (clk),
            .rst_n(rst_n),
            .shift(in_take),
            .din  (lane_in[l]),
            .taps (taps)
        );

        resamp_farrow #(.SW(SW), .MUW(MUW), .RK(RK)) interp_i (
            .clk  (clk),
            .rst_n(rst_n),
            .x0   (taps[0*SW +: SW]),
            .x1   (taps[1*SW +: SW]),
            .x2   (taps[2*SW +: SW]),
            .x3   (taps[3*SW +: SW]),
            .mu   (mu),
            .y    (lane_out[l])
        );
    end

    // Counts captured samples up to the delay-line depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                                fill <= '0;
        else if (in_take && (fill < FILL_W'(TAPS))) fill <= fill + 1'b1;
    end

    // Output valid is raised once the delay line holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= (fill == FILL_W'(TAPS));
    end

    // R9: valid never drops without a reset, and the fill count stays capped.
    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
    p_fill_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(TAPS));
    // R4: any divided strobe coincides with a take.
    p_div_in_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_div != '0) |-> in_take);
endmodule

// File: tb/farrow_resampler_tb_top.sv
`timescale 1ns/1ps
module farrow_resampler_tb_top;
    localparam int SW = 12, ACC_W = 32, CORR_W = 16, MUW = 12, NDIV = 3;
    localparam int WD_CYC = 100000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [ACC_W-1:0]  fcw = '0;
    logic [CORR_W-1:0] freq_corr = '0;
    logic [SW-1:0]     in_i = '0, in_q = '0;
    logic              in_take, out_valid;
    logic [NDIV-1:0]   stb_div;
    logic [SW-1:0]     out_i, out_q;

    farrow_resampler dut_i (
        .clk(clk), .rst_n(rst_n), .fcw(fcw), .freq_corr(freq_corr),
        .in_i(in_i), .in_q(in_q), .in_take(in_take), .stb_div(stb_div),
        .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // Reference model state.
    logic [31:0] macc;
    int mt [2][4];
    int mfill, mwcnt, ntake, kind, seen_take;
    bit have_exp, exp_valid;
    int exp_o [2];
    int exp_mu;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic int pat(input int k, input int n, input int lane);
        int unsigned h;
        case (k)
            0: return ((n * 97 + lane * 500) % 4096) - 2048;
            1: return (((n + lane) % 2) == 0) ? 2047 : -2048;
            2: begin
                h = 32'(n) * 32'd2654435761 + 32'(lane) * 32'd40503 + 32'd12345;
                return int'((h >> 9) & 32'd4095) - 2048;
            end
            default: return lane ? -1000 : 1234;
        endcase
    endfunction

    // Cubic through (-2,a) (-1,b) (0,c) (1,d) at m/2^MUW, rounded and clamped.
    function automatic int ref_val(input int a, input int b, input int c, input int d, input int m);
        real ra, rb, rc, rd, x, k3, k2, k1, p;
        int r;
        ra = a; rb = b; rc = c; rd = d;
        x  = m / real'(1 << MUW);
        k3 = (rd - ra) / 6.0 + (rb - rc) / 2.0;
        k2 = (rd + rb) / 2.0 - rc;
        k1 = (rd - rb) / 2.0 - k3;
        p  = ((k3 * x + k2) * x + k1) * x + rc;
        r  = $rtoi($floor(p + 0.5));
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports.
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(out_i == '0, "R1 out_i after reset", int'($signed(out_i)), 0);
        chk(out_q == '0, "R1 out_q after reset", int'($signed(out_q)), 0);
        rst_n = 1'b1;
        macc = '0; mfill = 0; mwcnt = 0; ntake = 0; seen_take = 0; have_exp = 0;
        for (int l = 0; l < 2; l++) for (int t = 0; t < 4; t++) mt[l][t] = 0;
    endtask

    task automatic step_cycle();
        logic [31:0] stp;
        logic [32:0] sm;
        bit tk;
        int act;
        // Compare registered outputs produced by the previous edge.
        if (have_exp) begin
            chk(out_valid == exp_valid, "R9 out_valid", out_valid, exp_valid);
            if (exp_valid) begin
                for (int l = 0; l < 2; l++) begin
                    act = (l == 0) ? int'($signed(out_i)) : int'($signed(out_q));
                    if (exp_mu == 0)
                        chk(act == exp_o[l], (l == 0) ? "R7/R5 I exact at mu=0" : "R7 R10 Q exact at mu=0", act, exp_o[l]);
                    else if (exp_o[l] == 2047 || exp_o[l] == -2048)
                        chk((act - exp_o[l]) <= 1 && (exp_o[l] - act) <= 1, (l == 0) ? "R8 I clamp" : "R8 R10 Q clamp", act, exp_o[l]);
                    else
                        chk((act - exp_o[l]) <= 1 && (exp_o[l] - act) <= 1, (l == 0) ? "R6 I interp" : "R6 R10 Q interp", act, exp_o[l]);
                end
            end
        end
        in_i = 12'(pat(kind, ntake, 0));
        in_q = 12'(pat(kind, ntake, 1));
        #1;
        stp = fcw + {{(32-CORR_W){freq_corr[CORR_W-1]}}, freq_corr};
        sm  = {1'b0, macc} + {1'b0, stp};
        tk  = sm[32];
        chk(in_take == tk, "R2 in_take", in_take, tk);
        if (in_take) seen_take++;
        for (int k = 0; k < NDIV; k++)
            chk(stb_div[k] == (tk && ((mwcnt % (2 << k)) == 0)), "R4 stb_div", stb_div[k],
                tk && ((mwcnt % (2 << k)) == 0));
        // Predict the registered outputs for the coming edge.
        exp_valid = (mfill == 4);
        exp_mu    = int'(macc[31:20]);
        for (int l = 0; l < 2; l++)
            exp_o[l] = ref_val(mt[l][3], mt[l][2], mt[l][1], mt[l][0], exp_mu);
        have_exp = 1;
        // Apply the edge to the model.
        macc = sm[31:0];
        if (tk) begin
            for (int l = 0; l < 2; l++) begin
                for (int t = 3; t > 0; t--) mt[l][t] = mt[l][t-1];
                mt[l][0] = pat(kind, ntake, l);
            end
            ntake++;
            mwcnt = (mwcnt + 1) % 8;
            if (mfill < 4) mfill++;
        end
        @(negedge clk);
    endtask

    task automatic run(input logic [31:0] f, input int corr, input int k, input int ncyc);
        longint unsigned stp, want;
        fcw = f;
        freq_corr = 16'(corr);
        kind = k;
        do_reset();
        for (int c = 0; c < ncyc; c++) step_cycle();
        stp  = longint'(32'(f + {{16{freq_corr[15]}}, freq_corr}));
        want = (longint'(ncyc) * stp) >> 32;
        // R3: take count matches the signed-corrected rate.
        chk(longint'(seen_take) == want, "R3 take count", seen_take, want);
    endtask

    initial begin
        @(negedge clk);
        run(32'h4000_0000, 0, 0, 600);        // quarter rate, mu on a 1/4 grid
        run(32'h0010_0000, 0, 2, 4300);       // every fraction value between takes
        run(32'h5555_5555, 0, 2, 1500);       // non-integer ratio
        run(32'hC000_0000, -1000, 1, 600);    // full-scale toggling, clamping
        run(32'h1000_0000, 32767, 3, 400);    // positive correction, constant input
        run(32'h8000_0000, -32768, 2, 800);   // negative correction
        run(32'h2345_6789, 4660, 0, 2500);    // irregular step, ramp input
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule